// File: doc/BRIEF.md
# Hot-Plug Interrupt and Link-Maintenance Monitor

This block sits on the source side of a display link and watches the hot-plug-detect line. A free-running microsecond tick is derived from the system clock. Each low period is timed and sorted into one of three kinds: a glitch, which is ignored; a short interrupt pulse from the sink; or an unplug. The block reports plug and unplug as single-cycle events.

Each interrupt triggers a read of the sink's six-byte link-status block through a sideband request port. The block then checks the per-lane lock flags of the lanes currently in use. If the link has degraded, it rewrites the link rate and lane count, sets the training pattern, and pulses a retrain request to the training controller. The request carries the rate and lane count that were in use when the decision was taken.

A status read that gets no answer before its deadline is withdrawn and treated as a degraded link. An interrupt that arrives while a read or retrain sequence is still running is held and served afterwards.

Top module: `hpd_link_monitor`

## Requirements
- R1: After reset the block treats the sink as unplugged and holds every output low. The first high level of the synchronised line while unplugged produces a one-cycle `evt_connect`.
- R2: While plugged, a low period shorter than `GLITCH_US` microseconds has no effect: no event, no sideband request and no retrain.
- R3: While plugged, a low period of at least `GLITCH_US` but under `UNPLUG_US` microseconds that ends with a return high is an interrupt. It starts a status read: `sb_write`=0, `sb_addr`=0x0200, with six bytes returned on `sb_rdata`.
- R4: A low period that reaches `UNPLUG_US` microseconds produces exactly one `evt_disconnect`. The next return high produces `evt_connect`.
- R5: Once raised, a write request holds `sb_req`, `sb_addr` and `sb_wdata` unchanged until the cycle `sb_ack` is seen. `sb_req` then drops for at least one cycle.
- R6: Byte k of `sb_rdata` occupies bits 8k+7..8k and holds address 0x0200+k. Lane n's flags are in byte 2+n/2, in the low nibble for even n and the high nibble for odd n. Within that nibble, bit 0 is clock-recovery lock and bit 2 is symbol lock. Bit 0 of byte 4 is inter-lane alignment. The link is degraded when alignment is clear, or when any lane n < `link_lanes` lacks either lock flag. Flags of unused lanes are ignored. A healthy result produces no further traffic.
- R7: A degraded result leads to three writes, in this order: address 0x0100 with the rate, address 0x0101 with the lane count, then address 0x0102 with 0x21. After the last write is acknowledged, `rt_req` pulses for one cycle. `rt_rate`/`rt_lanes` carry `link_rate`/`link_lanes` as sampled when the read finished.
- R8: The pattern write (0x0102) is never requested before both the rate and the lane-count writes have been acknowledged. The lane-count write is never requested before the rate write has been acknowledged.
- R9: A status read that has no `sb_ack` within `DEADLINE_US` microseconds of being issued is withdrawn (`sb_req` drops). The retrain sequence of R7 then follows as if the link were degraded.
- R10: An interrupt that arrives while a read or retrain sequence is in progress is held and causes one further status read after the current sequence ends. An unplug discards a held interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hpd_in | input | 1 | Raw hot-plug-detect line, asynchronous |
| link_rate | input | 8 | Rate code of the link currently trained |
| link_lanes | input | LANE_W | Lane count currently in use (1, 2 or 4) |
| sb_req | output | 1 | Sideband request, held until acknowledged |
| sb_write | output | 1 | 1 = register write, 0 = status-block read |
| sb_addr | output | 16 | Register address of the request |
| sb_wdata | output | 8 | Write data |
| sb_ack | input | 1 | One-cycle completion of the pending request |
| sb_rdata | input | 48 | Six status bytes, valid with `sb_ack` on a read |
| evt_connect | output | 1 | One-cycle plug event |
| evt_disconnect | output | 1 | One-cycle unplug event |
| rt_req | output | 1 | One-cycle retrain request |
| rt_rate | output | 8 | Rate to retrain at, valid with `rt_req` |
| rt_lanes | output | LANE_W | Lane count to retrain with, valid with `rt_req` |

## Verification
The bench builds the block with `CLK_PER_US`=2, `GLITCH_US`=4, `UNPLUG_US`=20 and `DEADLINE_US`=50. With these values a glitch, an interrupt pulse, an unplug and an expired status-read deadline each take only tens to a few hundred clock cycles. The whole classification ladder and the timeout path can therefore be driven many times in one short run. A slow sideband responder is used to stack a second interrupt behind a pending read. Different lane counts expose the rule that flags of unused lanes are ignored.

// File: rtl/hpd_mon_pkg.sv
package hpd_mon_pkg;
  localparam logic [15:0] STATUS_BASE = 16'h0200;
  localparam logic [15:0] RATE_REG    = 16'h0100;
  localparam logic [15:0] LANES_REG   = 16'h0101;
  localparam logic [15:0] PATTERN_REG = 16'h0102;
  localparam logic [7:0]  TP1_NO_SCR  = 8'h21;

  typedef enum logic [2:0] {
    MS_IDLE,
    MS_READ,
    MS_WR_RATE,
    MS_WR_LANES,
    MS_WR_PAT,
    MS_NOTIFY
  } maint_state_t;
endpackage

// File: rtl/hpd_line_sampler.sv
module hpd_line_sampler #(
  parameter int CLK_PER_US = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic hpd_raw,
  output logic hpd_s,
  output logic us_tick
);
  localparam int TW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic [1:0]    sync_q;
  logic [TW-1:0] div_q;

  // two-flop synchroniser for the asynchronous line
  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b00;
    else     sync_q <= {sync_q[0], hpd_raw};
  end
  assign hpd_s = sync_q[1];

  // microsecond strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      us_tick <= 1'b0;
    end else if (div_q == TW'(CLK_PER_US - 1)) begin
      div_q   <= '0;
      us_tick <= 1'b1;
    end else begin
      div_q   <= div_q + 1'b1;
      us_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/hpd_pulse_classifier.sv
module hpd_pulse_classifier #(
  parameter int GLITCH_US = 250,
  parameter int UNPLUG_US = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic hpd_s,
  input  logic us_tick,
  output logic evt_connect,
  output logic evt_disconnect,
  output logic irq_pulse,
  output logic linked
);
  localparam int LW = $clog2(UNPLUG_US + 1);

  logic          prev_q;
  logic [LW-1:0] low_us;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q         <= 1'b0;
      low_us         <= '0;
      linked         <= 1'b0;
      evt_connect    <= 1'b0;
      evt_disconnect <= 1'b0;
      irq_pulse      <= 1'b0;
    end else begin
      prev_q         <= hpd_s;
      evt_connect    <= 1'b0;
      evt_disconnect <= 1'b0;
      irq_pulse      <= 1'b0;
      if (!hpd_s) begin
        if (us_tick && low_us != LW'(UNPLUG_US))
          low_us <= low_us + 1'b1;
        if (linked && us_tick && low_us == LW'(UNPLUG_US - 1)) begin
          linked         <= 1'b0;
          evt_disconnect <= 1'b1;
        end
      end else begin
        low_us <= '0;
        if (!prev_q) begin
          if (!linked) begin
            linked      <= 1'b1;
            evt_connect <= 1'b1;
          end else if (low_us >= LW'(GLITCH_US)) begin
            irq_pulse <= 1'b1;
          end
        end
      end
    end
  end

  // R1
  connect_after_high_chk: assert property (@(posedge clk) disable iff (rst)
    evt_connect |-> $past(hpd_s) && linked);
  // R4
  disconnect_while_low_chk: assert property (@(posedge clk) disable iff (rst)
    evt_disconnect |-> !linked && !hpd_s);
  // R3
  irq_only_linked_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> linked);
  // R2
  one_event_kind_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_connect, evt_disconnect, irq_pulse}));
endmodule

// File: rtl/link_status_eval.sv
module link_status_eval #(
  parameter int MAX_LANES = 4,
  parameter int LANE_W    = $clog2(MAX_LANES + 1)
) (
  input  logic [47:0]       status,
  input  logic [LANE_W-1:0] lanes,
  output logic              degraded
);
  logic [MAX_LANES-1:0] lane_bad;
  logic                 status_unused;

  for (genvar n = 0; n < MAX_LANES; n++) begin : g_lane
    localparam int BASE = 8 * (2 + n / 2) + 4 * (n % 2);
    assign lane_bad[n] = (lanes > LANE_W'(n)) &&
                         !(status[BASE] && status[BASE + 2]);
  end

  assign degraded      = (|lane_bad) || !status[32];
  assign status_unused = ^{status[15:0], status[47:33]};
endmodule

// File: rtl/link_maint_ctrl.sv
module link_maint_ctrl
  import hpd_mon_pkg::*;
#(
  parameter int DEADLINE_US = 100000,
  parameter int LANE_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              us_tick,
  input  logic              irq_pulse,
  input  logic              linked,
  input  logic              degraded,
  input  logic [7:0]        link_rate,
  input  logic [LANE_W-1:0] link_lanes,
  output logic              sb_req,
  output logic              sb_write,
  output logic [15:0]       sb_addr,
  output logic [7:0]        sb_wdata,
  input  logic              sb_ack,
  output logic              rt_req,
  output logic [7:0]        rt_rate,
  output logic [LANE_W-1:0] rt_lanes
);
  localparam int DW = $clog2(DEADLINE_US + 1);

  maint_state_t  state;
  logic          pend;
  logic [DW-1:0] dl_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= MS_IDLE;
      pend     <= 1'b0;
      dl_cnt   <= '0;
      sb_req   <= 1'b0;
      sb_write <= 1'b0;
      sb_addr  <= '0;
      sb_wdata <= '0;
      rt_req   <= 1'b0;
      rt_rate  <= '0;
      rt_lanes <= '0;
    end else begin
      rt_req <= 1'b0;
      if (!linked)                          pend <= 1'b0;
      else if (irq_pulse && state != MS_IDLE) pend <= 1'b1;
      case (state)
        MS_IDLE: begin
          if (irq_pulse || (pend && linked)) begin
            pend   <= 1'b0;
            dl_cnt <= '0;
            state  <= MS_READ;
          end
        end
        MS_READ: begin
          if (us_tick && dl_cnt != DW'(DEADLINE_US)) dl_cnt <= dl_cnt + 1'b1;
          if (!sb_req) begin
            sb_req   <= 1'b1;
            sb_write <= 1'b0;
            sb_addr  <= STATUS_BASE;
            sb_wdata <= '0;
          end else if (sb_ack) begin
            sb_req   <= 1'b0;
            rt_rate  <= link_rate;
            rt_lanes <= link_lanes;
            state    <= degraded ? MS_WR_RATE : MS_IDLE;
          end else if (dl_cnt == DW'(DEADLINE_US)) begin
            sb_req   <= 1'b0;
            rt_rate  <= link_rate;
            rt_lanes <= link_lanes;
            state    <= MS_WR_RATE;
          end
        end
        MS_WR_RATE: begin
          if (!sb_req) begin
            sb_req   <= 1'b1;
            sb_write <= 1'b1;
            sb_addr  <= RATE_REG;
            sb_wdata <= rt_rate;
          end else if (sb_ack) begin
            sb_req <= 1'b0;
            state  <= MS_WR_LANES;
          end
        end
        MS_WR_LANES: begin
          if (!sb_req) begin
            sb_req   <= 1'b1;
            sb_write <= 1'b1;
            sb_addr  <= LANES_REG;
            sb_wdata <= 8'(rt_lanes);
          end else if (sb_ack) begin
            sb_req <= 1'b0;
            state  <= MS_WR_PAT;
          end
        end
        MS_WR_PAT: begin
          if (!sb_req) begin
            sb_req   <= 1'b1;
            sb_write <= 1'b1;
            sb_addr  <= PATTERN_REG;
            sb_wdata <= TP1_NO_SCR;
          end else if (sb_ack) begin
            sb_req <= 1'b0;
            state  <= MS_NOTIFY;
          end
        end
        MS_NOTIFY: begin
          rt_req <= 1'b1;
          state  <= MS_IDLE;
        end
        default: state <= MS_IDLE;
      endcase
    end
  end

  // order tracking for the write-sequence checks
  logic saw_rate, saw_lanes;
  always_ff @(posedge clk) begin
    if (rst) begin
      saw_rate  <= 1'b0;
      saw_lanes <= 1'b0;
    end else if (sb_req && sb_ack && sb_write) begin
      if (sb_addr == RATE_REG)    saw_rate  <= 1'b1;
      if (sb_addr == LANES_REG)   saw_lanes <= 1'b1;
      if (sb_addr == PATTERN_REG) begin
        saw_rate  <= 1'b0;
        saw_lanes <= 1'b0;
      end
    end
  end

  // R8
  pattern_after_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (sb_req && sb_write && sb_addr == PATTERN_REG) |-> saw_rate && saw_lanes);
  // R8
  lanes_after_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (sb_req && sb_write && sb_addr == LANES_REG) |-> saw_rate);
  // R5
  write_held_chk: assert property (@(posedge clk) disable iff (rst)
    (sb_req && sb_write && !sb_ack) |=> sb_req && $stable(sb_addr) && $stable(sb_wdata));
  // R5
  gap_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (sb_req && sb_ack) |=> !sb_req);
  // R7
  retrain_single_chk: assert property (@(posedge clk) disable iff (rst)
    rt_req |=> !rt_req);
endmodule

// File: rtl/hpd_link_monitor.sv
module hpd_link_monitor #(
  parameter int CLK_PER_US  = 125,
  parameter int GLITCH_US   = 250,
  parameter int UNPLUG_US   = 2000,
  parameter int DEADLINE_US = 100000,
  parameter int MAX_LANES   = 4,
  parameter int LANE_W      = $clog2(MAX_LANES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hpd_in,
  input  logic [7:0]        link_rate,
  input  logic [LANE_W-1:0] link_lanes,
  output logic              sb_req,
  output logic              sb_write,
  output logic [15:0]       sb_addr,
  output logic [7:0]        sb_wdata,
  input  logic              sb_ack,
  input  logic [47:0]       sb_rdata,
  output logic              evt_connect,
  output logic              evt_disconnect,
  output logic              rt_req,
  output logic [7:0]        rt_rate,
  output logic [LANE_W-1:0] rt_lanes
);
  logic hpd_s, us_tick, irq_pulse, linked, degraded;

  hpd_line_sampler #(.CLK_PER_US(CLK_PER_US)) u_sampler (
    .clk(clk), .rst(rst), .hpd_raw(hpd_in), .hpd_s(hpd_s), .us_tick(us_tick)
  );

  hpd_pulse_classifier #(.GLITCH_US(GLITCH_US), .UNPLUG_US(UNPLUG_US)) u_classify (
    .clk(clk), .rst(rst), .hpd_s(hpd_s), .us_tick(us_tick),
    .evt_connect(evt_connect), .evt_disconnect(evt_disconnect),
    .irq_pulse(irq_pulse), .linked(linked)
  );

  link_status_eval #(.MAX_LANES(MAX_LANES), .LANE_W(LANE_W)) u_eval (
    .status(sb_rdata), .lanes(link_lanes), .degraded(degraded)
  );

  link_maint_ctrl #(.DEADLINE_US(DEADLINE_US), .LANE_W(LANE_W)) u_ctrl (
    .clk(clk), .rst(rst), .us_tick(us_tick), .irq_pulse(irq_pulse),
    .linked(linked), .degraded(degraded), .link_rate(link_rate),
    .link_lanes(link_lanes), .sb_req(sb_req), .sb_write(sb_write),
    .sb_addr(sb_addr), .sb_wdata(sb_wdata), .sb_ack(sb_ack),
    .rt_req(rt_req), .rt_rate(rt_rate), .rt_lanes(rt_lanes)
  );
endmodule

// File: tb/hpd_link_monitor_test.sv
module hpd_link_monitor_test;
  localparam int CPU = 2;
  localparam int GL  = 4;
  localparam int UP  = 20;
  localparam int DL  = 50;
  localparam int LW  = 3;

  localparam int K_CONN = 1, K_DISC = 2, K_RD = 3, K_WR = 4, K_RT = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hpd_in = 1'b0;
  logic [7:0]    link_rate = 8'h14;
  logic [LW-1:0] link_lanes = 3'd4;
  logic          sb_req, sb_write, sb_ack = 1'b0;
  logic [15:0]   sb_addr;
  logic [7:0]    sb_wdata;
  logic [47:0]   sb_rdata = '0;
  logic          evt_connect, evt_disconnect, rt_req;
  logic [7:0]    rt_rate;
  logic [LW-1:0] rt_lanes;

  always #4 clk = ~clk;

  hpd_link_monitor #(.CLK_PER_US(CPU), .GLITCH_US(GL), .UNPLUG_US(UP),
                     .DEADLINE_US(DL), .MAX_LANES(4), .LANE_W(LW)) uut (
    .clk(clk), .rst(rst), .hpd_in(hpd_in), .link_rate(link_rate),
    .link_lanes(link_lanes), .sb_req(sb_req), .sb_write(sb_write),
    .sb_addr(sb_addr), .sb_wdata(sb_wdata), .sb_ack(sb_ack),
    .sb_rdata(sb_rdata), .evt_connect(evt_connect),
    .evt_disconnect(evt_disconnect), .rt_req(rt_req), .rt_rate(rt_rate),
    .rt_lanes(rt_lanes)
  );

  typedef struct {
    int    kind;
    int    a;
    int    b;
    string tag;
  } item_t;

  item_t exp_q[$];
  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 0;

  int          resp_delay = 2;
  bit          mute_reads = 0;
  logic [47:0] resp_status = '0;

  task automatic expect_item(int kind, int a, int b, string tag);
    item_t it;
    it.kind = kind; it.a = a; it.b = b; it.tag = tag;
    exp_q.push_back(it);
  endtask

  function automatic void observe(int kind, int a, int b);
    item_t it;
    vectors++;
    if (exp_q.size() == 0) begin
      miscompares++;
      $display("FAIL R2/R6 unexpected item: got kind=%0d a=%0h b=%0h expected none", kind, a, b);
    end else begin
      it = exp_q.pop_front();
      if (it.kind != kind || it.a != a || it.b != b) begin
        miscompares++;
        $display("FAIL %s got kind=%0d a=%0h b=%0h expected kind=%0d a=%0h b=%0h",
                 it.tag, kind, a, b, it.kind, it.a, it.b);
      end
    end
  endfunction

  // monitor: samples away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (evt_connect)       observe(K_CONN, 0, 0);
      if (evt_disconnect)    observe(K_DISC, 0, 0);
      if (sb_req && sb_ack)  observe(sb_write ? K_WR : K_RD, int'(sb_addr),
                                     sb_write ? int'(sb_wdata) : 0);
      if (rt_req)            observe(K_RT, int'(rt_rate), int'(rt_lanes));
    end
  end

  // sideband responder, drives just after the rising edge
  initial begin
    int waitc;
    waitc = 0;
    forever begin
      @(posedge clk);
      #1;
      if (sb_ack) begin
        sb_ack = 1'b0;
        waitc  = 0;
      end else if (sb_req && !(mute_reads && !sb_write)) begin
        if (waitc >= resp_delay) begin
          sb_ack   = 1'b1;
          sb_rdata = resp_status;
        end else begin
          waitc++;
        end
      end else begin
        waitc = 0;
      end
    end
  end

  function automatic logic [47:0] mk_status(logic [3:0] cr, logic [3:0] sl, logic align);
    logic [47:0] s;
    s = '0;
    for (int n = 0; n < 4; n++) begin
      s[8 * (2 + n / 2) + 4 * (n % 2)]     = cr[n];
      s[8 * (2 + n / 2) + 4 * (n % 2) + 2] = sl[n];
    end
    s[32] = align;
    return s;
  endfunction

  task automatic wait_us(int us);
    repeat (us * CPU) @(negedge clk);
  endtask

  task automatic low_pulse(int us);
    @(negedge clk);
    hpd_in = 1'b0;
    wait_us(us);
    hpd_in = 1'b1;
  endtask

  task automatic drain(int cycles, string tag);
    repeat (cycles) @(negedge clk);
    vectors++;
    if (exp_q.size() != 0) begin
      miscompares++;
      $display("FAIL %s got %0d pending items expected 0 (first kind=%0d)",
               tag, exp_q.size(), exp_q[0].kind);
      exp_q.delete();
    end
  endtask

  task automatic expect_retrain(int rate, int lanes, string tag);
    expect_item(K_WR, 16'h0100, rate, {tag, " R7 rate write"});
    expect_item(K_WR, 16'h0101, lanes, {tag, " R8 lanes write"});
    expect_item(K_WR, 16'h0102, 8'h21, {tag, " R8 pattern write"});
    expect_item(K_RT, rate, lanes, {tag, " R7 retrain request"});
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired: got hung run expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    vectors++;
    if ({sb_req, evt_connect, evt_disconnect, rt_req} != 4'b0) begin
      miscompares++;
      $display("FAIL R1 reset outputs got %b expected 0000",
               {sb_req, evt_connect, evt_disconnect, rt_req});
    end

    // R1 plug in
    expect_item(K_CONN, 0, 0, "R1 connect");
    hpd_in = 1'b1;
    drain(40, "R1 connect");

    // R2 glitch ignored
    low_pulse(2);
    drain(150, "R2 glitch");

    // R3 healthy interrupt, four lanes
    resp_status = mk_status(4'hF, 4'hF, 1'b1);
    expect_item(K_RD, 16'h0200, 0, "R3 status read");
    low_pulse(10);
    drain(150, "R3 healthy");

    // R6/R7 lane 3 lost clock recovery with four lanes active
    resp_status = mk_status(4'b0111, 4'hF, 1'b1);
    expect_item(K_RD, 16'h0200, 0, "R6 status read");
    expect_retrain(8'h14, 4, "R6 lane3 cr");
    low_pulse(10);
    drain(200, "R7 lane3 cr");

    // R6 same flags, two lanes active: unused lane ignored
    link_lanes  = 3'd2;
    expect_item(K_RD, 16'h0200, 0, "R6 two-lane read");
    low_pulse(10);
    drain(150, "R6 unused lane ignored");

    // R6 one lane, symbol lock lost on lane 0
    link_lanes  = 3'd1;
    link_rate   = 8'h0A;
    resp_status = mk_status(4'hF, 4'b1110, 1'b1);
    expect_item(K_RD, 16'h0200, 0, "R6 one-lane read");
    expect_retrain(8'h0A, 1, "R6 lane0 symlock");
    low_pulse(10);
    drain(200, "R6 lane0 symlock");

    // R6 alignment lost
    link_lanes  = 3'd4;
    link_rate   = 8'h14;
    resp_status = mk_status(4'hF, 4'hF, 1'b0);
    expect_item(K_RD, 16'h0200, 0, "R6 align read");
    expect_retrain(8'h14, 4, "R6 align lost");
    low_pulse(10);
    drain(200, "R6 align lost");

    // R9 no answer to the read: withdrawn, retrain follows
    mute_reads  = 1;
    resp_status = mk_status(4'hF, 4'hF, 1'b1);
    expect_retrain(8'h14, 4, "R9 deadline");
    low_pulse(10);
    drain(DL * CPU + 150, "R9 deadline");
    mute_reads = 0;

    // R10 second interrupt while the first read is pending
    resp_delay = 60;
    expect_item(K_RD, 16'h0200, 0, "R10 first read");
    expect_item(K_RD, 16'h0200, 0, "R10 queued read");
    low_pulse(10);
    wait_us(2);
    low_pulse(10);
    drain(300, "R10 queued");
    resp_delay = 2;

    // R4 unplug then replug
    expect_item(K_DISC, 0, 0, "R4 disconnect");
    @(negedge clk);
    hpd_in = 1'b0;
    wait_us(30);
    drain(10, "R4 disconnect");
    expect_item(K_CONN, 0, 0, "R4 reconnect");
    hpd_in = 1'b1;
    drain(40, "R4 reconnect");

    // R3 interrupt after reconnect still served
    expect_item(K_RD, 16'h0200, 0, "R3 read after reconnect");
    low_pulse(10);
    drain(150, "R3 after reconnect");

    finish_run();
  end
endmodule